// File: doc/BRIEF.md
# Loop Replay Qualifier

This block decides whether a short loop can be replayed straight out of the micro-op queue rather than being fetched and decoded again. The front end presents the decoded micro-ops of one candidate loop body, one per cycle. The body begins right after the previous loop-closing branch, or after reset, a misprediction or a flush. It ends with a micro-op flagged as the loop-closing backward taken branch.

Each micro-op carries these fields:
- a fetch-chunk index;
- a taken-branch flag;
- call and return flags;
- push and pop flags;
- a flag saying the micro-op is also held in the decoded micro-op cache.

The block keeps running totals over the body. When the closing branch arrives it emits a one-cycle verdict saying whether the loop qualifies. A qualifying verdict starts replay. While replay is active no fetch takes place, so the block ignores micro-op traffic. A branch misprediction or a flush ends replay.

Top module: `loop_qualifier`

## Requirements
- R1: After reset, `verdict_valid`, `verdict_ok` and `replay_active` are all 0.
- R2: The micro-op count of a body includes the closing branch. A body of up to 28 micro-ops can qualify, and a body of 29 or more is rejected.
- R3: The chunk count of a body is 1 plus the number of its micro-ops whose `uop_chunk` differs from that of the micro-op before it in the same body. A body that spans up to 8 chunks can qualify, and one that spans 9 or more is rejected.
- R4: The taken-branch count covers every micro-op with `uop_taken`=1, and it always includes the closing branch. Up to 8 taken branches can qualify, and 9 or more are rejected.
- R5: Any micro-op in the body with `uop_call`=1 or `uop_ret`=1 causes rejection.
- R6: A signed balance takes +1 for each push and −1 for each pop; a micro-op with both flags set adds 0. A body qualifies only if the balance is zero at the closing branch, so an excess of either pushes or pops causes rejection.
- R7: Any micro-op in the body with `uop_cached`=0 causes rejection.
- R8: When an accepted micro-op has `uop_close`=1, `verdict_valid` is 1 in the next cycle only. In that cycle `verdict_ok` is 1 exactly when every limit of R2 to R7 holds, and `verdict_ok` is 0 in every cycle in which `verdict_valid` is 0.
- R9: A qualifying verdict sets `replay_active` in the same cycle as that verdict. `replay_active` then stays 1 until `mispredict` or `flush` is seen, and it is 0 from the following cycle. A rejecting verdict leaves `replay_active` at 0.
- R10: While `replay_active` is 1, micro-ops, including closing ones, produce no verdict and are not counted. The body that follows the end of replay starts empty.
- R11: A `mispredict` or `flush` while a body is being gathered discards that body. If it arrives in the same cycle as a closing micro-op, no verdict is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 1 | A micro-op descriptor is present this cycle |
| uop_chunk | input | CHUNK_W | Fetch-chunk index of the micro-op |
| uop_taken | input | 1 | Micro-op is a taken branch |
| uop_call | input | 1 | Micro-op is a call |
| uop_ret | input | 1 | Micro-op is a return |
| uop_push | input | 1 | Micro-op pushes onto the stack |
| uop_pop | input | 1 | Micro-op pops from the stack |
| uop_cached | input | 1 | Micro-op is resident in the decoded micro-op cache |
| uop_close | input | 1 | Micro-op is the loop-closing backward taken branch |
| mispredict | input | 1 | Branch misprediction signalled |
| flush | input | 1 | Pipeline flush |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_ok | output | 1 | The loop qualifies; meaningful with verdict_valid |
| replay_active | output | 1 | The loop is being replayed from the queue |

## Verification
- **Limit bodies.** Loop bodies are driven that sit exactly at, and exactly one above, each count limit: micro-ops, chunks and taken branches. Each such pair isolates one comparison and shows whether the closing branch itself is counted.
- **Single-defect bodies.** Other bodies stay within every count limit and carry exactly one defect: a call, a return, a surplus push, a surplus pop, or one micro-op that is not cached. Each shows that this condition alone forces a rejection.
- **Counter-reset patterns.** Some patterns send traffic during replay, discard a half-gathered body with a flush, or raise a misprediction alongside a closing branch. Each is followed by a full 28-micro-op body, which qualifies only if the counters really started empty.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam int CNT_W = 8;
  localparam int BAL_W = 8;

  typedef logic [CNT_W-1:0]        cnt_t;
  typedef logic signed [BAL_W-1:0] bal_t;

  typedef struct packed {
    logic taken;
    logic call;
    logic ret;
    logic push;
    logic pop;
    logic cached;
    logic close;
  } uop_flags_t;

  // Increment when enabled, holding at cap once reached.
  function automatic cnt_t sat_inc(cnt_t v, logic en, cnt_t cap);
    if (en && (v < cap)) return v + cnt_t'(1);
    return v;
  endfunction

  // Net stack effect of one micro-op.
  function automatic bal_t bal_step(bal_t b, logic push, logic pop);
    if (push && !pop) return b + bal_t'(1);
    if (pop && !push) return b - bal_t'(1);
    return b;
  endfunction

  // True when the step would leave the signed range.
  function automatic logic bal_wraps(bal_t b, logic push, logic pop);
    bal_t top;
    bal_t bot;
    top = {1'b0, {(BAL_W-1){1'b1}}};
    bot = {1'b1, {(BAL_W-1){1'b0}}};
    return (push && !pop && b == top) || (pop && !push && b == bot);
  endfunction

endpackage

// File: rtl/lsq_accum.sv
module lsq_accum
  import lsq_pkg::*;
#(
  parameter int CHUNK_W    = 4,
  parameter int MAX_UOPS   = 28,
  parameter int MAX_CHUNKS = 8,
  parameter int MAX_TAKEN  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               clear,
  input  logic [CHUNK_W-1:0] chunk,
  input  uop_flags_t         flags,
  output cnt_t               tot_uops,
  output cnt_t               tot_chunks,
  output cnt_t               tot_taken,
  output bal_t               tot_bal,
  output logic               tot_ovf,
  output logic               tot_bad
);

  localparam cnt_t U_CAP = cnt_t'(MAX_UOPS + 1);
  localparam cnt_t C_CAP = cnt_t'(MAX_CHUNKS + 1);
  localparam cnt_t T_CAP = cnt_t'(MAX_TAKEN + 1);

  cnt_t               ucnt_q, ccnt_q, tcnt_q;
  bal_t               bal_q;
  logic               ovf_q, bad_q, have_prev_q;
  logic [CHUNK_W-1:0] prev_chunk_q;

  // Named events for the checks below.
  logic new_chunk;
  logic taken_ev;
  logic defect_ev;

  assign new_chunk = accept && (!have_prev_q || chunk != prev_chunk_q);
  assign taken_ev  = accept && (flags.taken || flags.close);
  assign defect_ev = accept && (flags.call || flags.ret || !flags.cached);

  always_comb begin
    tot_uops   = sat_inc(ucnt_q, accept, U_CAP);
    tot_chunks = sat_inc(ccnt_q, new_chunk, C_CAP);
    tot_taken  = sat_inc(tcnt_q, taken_ev, T_CAP);
    tot_bal    = accept ? bal_step(bal_q, flags.push, flags.pop) : bal_q;
    tot_ovf    = ovf_q || (accept && bal_wraps(bal_q, flags.push, flags.pop));
    tot_bad    = bad_q || defect_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ucnt_q       <= '0;
      ccnt_q       <= '0;
      tcnt_q       <= '0;
      bal_q        <= '0;
      ovf_q        <= 1'b0;
      bad_q        <= 1'b0;
      have_prev_q  <= 1'b0;
      prev_chunk_q <= '0;
    end else if (accept) begin
      ucnt_q       <= tot_uops;
      ccnt_q       <= tot_chunks;
      tcnt_q       <= tot_taken;
      bal_q        <= tot_bal;
      ovf_q        <= tot_ovf;
      bad_q        <= tot_bad;
      have_prev_q  <= 1'b1;
      prev_chunk_q <= chunk;
    end
  end

  AST_CHUNKS_LE_UOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt_q <= ucnt_q); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ucnt_q == '0 && tcnt_q == '0 && bal_q == '0 && !bad_q)); // R10

  AST_UOPS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ucnt_q <= U_CAP); // R2

endmodule

// File: rtl/lsq_judge.sv
module lsq_judge
  import lsq_pkg::*;
#(
  parameter int MAX_UOPS   = 28,
  parameter int MAX_CHUNKS = 8,
  parameter int MAX_TAKEN  = 8
) (
  input  cnt_t tot_uops,
  input  cnt_t tot_chunks,
  input  cnt_t tot_taken,
  input  bal_t tot_bal,
  input  logic tot_ovf,
  input  logic tot_bad,
  output logic ok
);

  localparam cnt_t U_LIM = cnt_t'(MAX_UOPS);
  localparam cnt_t C_LIM = cnt_t'(MAX_CHUNKS);
  localparam cnt_t T_LIM = cnt_t'(MAX_TAKEN);

  logic uops_fit, chunks_fit, taken_fit, stack_even;

  assign uops_fit   = tot_uops <= U_LIM;
  assign chunks_fit = tot_chunks <= C_LIM;
  assign taken_fit  = tot_taken <= T_LIM;
  assign stack_even = (tot_bal == '0) && !tot_ovf;

  assign ok = uops_fit && chunks_fit && taken_fit && stack_even && !tot_bad;

endmodule

// File: rtl/lsq_replay.sv
module lsq_replay (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic judge_ok,
  input  logic kill,
  output logic verdict_valid,
  output logic verdict_ok,
  output logic replay_active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_ok    <= 1'b0;
      replay_active <= 1'b0;
    end else begin
      verdict_valid <= fire;
      verdict_ok    <= fire && judge_ok;
      if (fire && judge_ok) replay_active <= 1'b1;
      else if (kill)        replay_active <= 1'b0;
    end
  end

  AST_REPLAY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_active && kill) |=> !replay_active); // R9

  AST_OK_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_ok |-> verdict_valid); // R8

endmodule

// File: rtl/loop_qualifier.sv
module loop_qualifier
  import lsq_pkg::*;
#(
  parameter int CHUNK_W    = 4,
  parameter int MAX_UOPS   = 28,
  parameter int MAX_CHUNKS = 8,
  parameter int MAX_TAKEN  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               uop_valid,
  input  logic [CHUNK_W-1:0] uop_chunk,
  input  logic               uop_taken,
  input  logic               uop_call,
  input  logic               uop_ret,
  input  logic               uop_push,
  input  logic               uop_pop,
  input  logic               uop_cached,
  input  logic               uop_close,
  input  logic               mispredict,
  input  logic               flush,
  output logic               verdict_valid,
  output logic               verdict_ok,
  output logic               replay_active
);

  uop_flags_t flags;
  logic       kill, accept, fire, judge_ok;
  cnt_t       tot_uops, tot_chunks, tot_taken;
  bal_t       tot_bal;
  logic       tot_ovf, tot_bad;

  assign flags  = '{taken: uop_taken, call: uop_call, ret: uop_ret, push: uop_push,
                    pop: uop_pop, cached: uop_cached, close: uop_close};
  assign kill   = mispredict || flush;
  assign accept = uop_valid && !replay_active && !kill;
  assign fire   = accept && uop_close;

  lsq_accum #(
    .CHUNK_W(CHUNK_W), .MAX_UOPS(MAX_UOPS),
    .MAX_CHUNKS(MAX_CHUNKS), .MAX_TAKEN(MAX_TAKEN)
  ) i_accum (
    .clk(clk), .rst_n(rst_n), .accept(accept), .clear(kill || fire),
    .chunk(uop_chunk), .flags(flags),
    .tot_uops(tot_uops), .tot_chunks(tot_chunks), .tot_taken(tot_taken),
    .tot_bal(tot_bal), .tot_ovf(tot_ovf), .tot_bad(tot_bad)
  );

  lsq_judge #(
    .MAX_UOPS(MAX_UOPS), .MAX_CHUNKS(MAX_CHUNKS), .MAX_TAKEN(MAX_TAKEN)
  ) i_judge (
    .tot_uops(tot_uops), .tot_chunks(tot_chunks), .tot_taken(tot_taken),
    .tot_bal(tot_bal), .tot_ovf(tot_ovf), .tot_bad(tot_bad), .ok(judge_ok)
  );

  lsq_replay i_replay (
    .clk(clk), .rst_n(rst_n), .fire(fire), .judge_ok(judge_ok), .kill(kill),
    .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .replay_active(replay_active)
  );

  AST_VERDICT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(uop_valid && uop_close && !mispredict && !flush)); // R8

  AST_REPLAY_RISE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_active) |-> (verdict_valid && verdict_ok)); // R9

  AST_QUIET_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_active && !kill) |=> !verdict_valid); // R10

  AST_KILL_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !verdict_valid); // R11

endmodule

// File: tb/test_loop_qualifier.sv
module test_loop_qualifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uop_valid = 1'b0;
  logic [3:0] uop_chunk = '0;
  logic       uop_taken = 1'b0, uop_call = 1'b0, uop_ret = 1'b0;
  logic       uop_push = 1'b0, uop_pop = 1'b0, uop_cached = 1'b0, uop_close = 1'b0;
  logic       mispredict = 1'b0, flush = 1'b0;
  logic       verdict_valid, verdict_ok, replay_active;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];

  always #2 clk = ~clk;

  loop_qualifier i_loop_qualifier (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_chunk(uop_chunk),
    .uop_taken(uop_taken), .uop_call(uop_call), .uop_ret(uop_ret),
    .uop_push(uop_push), .uop_pop(uop_pop), .uop_cached(uop_cached),
    .uop_close(uop_close), .mispredict(mispredict), .flush(flush),
    .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .replay_active(replay_active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every verdict strobe is matched against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && verdict_valid) begin
      if (exp_q.size() == 0) check("R10/R11 unexpected verdict", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check("R8 verdict_ok", int'(verdict_ok), int'(e));
      end
    end
  end

  task automatic idle_inputs();
    uop_valid = 0; uop_taken = 0; uop_call = 0; uop_ret = 0;
    uop_push = 0; uop_pop = 0; uop_cached = 0; uop_close = 0;
  endtask

  // Drives one body; the expected verdict comes from the limits alone.
  task automatic drive_body(input int n, input int nch, input int ntk,
                            input int npush, input int npop, input bit with_call,
                            input bit with_ret, input bit one_uncached, input string tag);
    bit exp_ok;
    exp_ok = (n <= 28) && (nch <= 8) && (ntk <= 8) && (npush == npop)
             && !with_call && !with_ret && !one_uncached;
    exp_q.push_back(exp_ok);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      uop_valid  = 1;
      uop_chunk  = 4'((i * nch) / n);
      uop_taken  = (i < ntk - 1) && (i < n - 1);
      uop_call   = with_call && (i == 0);
      uop_ret    = with_ret && (i == 1);
      uop_push   = (i < npush);
      uop_pop    = (i >= n - npop);
      uop_cached = !(one_uncached && (i == n / 2));
      uop_close  = (i == n - 1);
    end
    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk);
    check({tag, " R8 strobe"}, int'(verdict_valid), 1);
    check({tag, " R9 replay after verdict"}, int'(replay_active), int'(exp_ok));
    @(negedge clk);
    check({tag, " R8 strobe single cycle"}, int'(verdict_valid), 0);
  endtask

  task automatic end_replay(input bit use_flush);
    @(posedge clk); #1;
    if (use_flush) flush = 1; else mispredict = 1;
    @(posedge clk); #1;
    flush = 0; mispredict = 0;
    @(negedge clk);
    check("R9 replay cleared", int'(replay_active), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 verdict_valid", int'(verdict_valid), 0);
    check("R1 verdict_ok", int'(verdict_ok), 0);
    check("R1 replay_active", int'(replay_active), 0);

    // Basic qualifying loop, replay held through idle cycles.
    drive_body(10, 3, 2, 2, 2, 0, 0, 0, "R8 basic");
    repeat (5) @(negedge clk);
    check("R9 replay held", int'(replay_active), 1);
    end_replay(0);

    // Micro-op count boundary.
    drive_body(28, 4, 3, 0, 0, 0, 0, 0, "R2 28");
    end_replay(1);
    drive_body(29, 4, 3, 0, 0, 0, 0, 0, "R2 29");

    // Chunk boundary.
    drive_body(20, 8, 2, 0, 0, 0, 0, 0, "R3 8ch");
    end_replay(0);
    drive_body(20, 9, 2, 0, 0, 0, 0, 0, "R3 9ch");

    // Taken-branch boundary.
    drive_body(16, 2, 8, 0, 0, 0, 0, 0, "R4 8tk");
    end_replay(0);
    drive_body(16, 2, 9, 0, 0, 0, 0, 0, "R4 9tk");

    // Call and return.
    drive_body(8, 1, 1, 0, 0, 1, 0, 0, "R5 call");
    drive_body(8, 1, 1, 0, 0, 0, 1, 0, "R5 ret");

    // Stack balance.
    drive_body(12, 2, 1, 3, 2, 0, 0, 0, "R6 push excess");
    drive_body(12, 2, 1, 2, 3, 0, 0, 0, "R6 pop excess");
    drive_body(12, 2, 1, 4, 4, 0, 0, 0, "R6 balanced");
    end_replay(0);

    // Residency.
    drive_body(12, 2, 1, 0, 0, 0, 0, 1, "R7 uncached");

    // Traffic during replay is ignored; the next body starts empty.
    drive_body(6, 1, 1, 0, 0, 0, 0, 0, "R10 setup");
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      uop_valid = 1; uop_call = 1; uop_cached = 1; uop_chunk = 4'(i); uop_close = (i == 4);
    end
    @(posedge clk); #1;
    idle_inputs();
    @(negedge clk);
    check("R10 no verdict in replay", int'(verdict_valid), 0);
    check("R10 replay still held", int'(replay_active), 1);
    end_replay(0);
    drive_body(28, 8, 8, 0, 0, 0, 0, 0, "R10 full after replay");
    end_replay(0);

    // Flush discards a partial body.
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      uop_valid = 1; uop_cached = 1; uop_chunk = 4'(i); uop_taken = 1;
    end
    @(posedge clk); #1;
    idle_inputs(); flush = 1;
    @(posedge clk); #1;
    flush = 0;
    drive_body(28, 8, 8, 0, 0, 0, 0, 0, "R11 after flush");
    end_replay(1);

    // Mispredict alongside a closing micro-op.
    @(posedge clk); #1;
    uop_valid = 1; uop_cached = 1; uop_close = 1; mispredict = 1;
    @(posedge clk); #1;
    idle_inputs(); mispredict = 0;
    @(negedge clk);
    check("R11 no verdict with mispredict", int'(verdict_valid), 0);
    drive_body(28, 5, 4, 1, 1, 0, 0, 0, "R11 after mispredict");
    end_replay(0);

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule